// File: doc/BRIEF.md
# Five-Level Fourth-Order Noise-Shaping Modulator

This block turns a stream of oversampled 16-bit two's-complement audio samples into a stream of five-level codes for a multi-bit DAC. Each instance handles one channel. A new sample arrives with a strobe at eight times the audio rate. The modulator then runs four or six loop steps on that sample before the next strobe. The count depends on the system clock ratio the chip is set to.

The loop filter is a chain of four delaying integrators. A feedforward sum of shifted state values feeds the quantizer. Two inner feedback paths, each scaled by a power of two, give phase compensation. The quantizer maps the filter sum onto the codes 0 to 4. The chosen code becomes a centred feedback value equal to (code - 2) times a quarter of the 16-bit full scale. This value is subtracted from the input at the summing node. Every integrator saturates rather than wrapping. All coefficients are shift parameters, so the datapath needs adders only and no multiplier.

Top module: `dsm5_modulator`

## Requirements
- R1: `lvl_o` only ever carries a code in the range 0 to 4.
- R2: While `rst` is high at a clock edge, the next cycle shows `lvl_o` = 2 and `lvl_valid_o` = 0. All integrator states are cleared, so a run of zero samples after reset yields code 2 on every step.
- R3: Starting from reset, a zero input sample gives code 2 on every loop step.
- R4: A strobe on `in_valid` starts a burst of loop steps. The burst has 4 steps when `rate_sel` = 0 at the strobe and 6 steps when `rate_sel` = 1. `lvl_valid_o` is high for exactly those cycles, starting in the second cycle after the strobe cycle.
- R5: `in_data` and `rate_sel` are sampled only in a strobe cycle. Their values in other cycles have no effect on the output.
- R6: For a constant input x over a window of loop steps, the sum of (code - 2) * 2^14 over the window differs from (steps * x) by at most 2^22. The long-run mean code is therefore 2 + x / 2^14.
- R7: `lvl_o` changes only in cycles where `lvl_valid_o` is high.
- R8: Full-scale inputs (+32767 and -32768) still track as in R6, and the first integrator never reaches its saturation limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one loop step per cycle during a burst |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| rate_sel | input | 1 | Burst length select at the strobe: 0 gives 4 steps, 1 gives 6 |
| in_data | input | 16 | Two's-complement input sample |
| lvl_o | output | 3 | Quantizer code, 0 to 4 |
| lvl_valid_o | output | 1 | High in each cycle that carries a new code |

## Verification
The loop is driven with five kinds of input.
- A zero input after reset must give a flat code 2. This separates a correctly centred quantizer and cleared state from any offset or leftover state.
- Half-scale inputs of both signs and a quarter-scale input must give mean codes near 3, 1 and 2.5. These expose errors in sign, feedback scaling and proportionality.
- The two full-scale extremes test that overload saturates instead of wrapping.
- Between strobes, `in_data` and `rate_sel` are filled with garbage. A zero run that stays exactly at code 2 therefore shows that only strobed values enter the loop.
- Single strobes at both rates measure the burst length and its start cycle.

// File: rtl/dsm5_pkg.sv
`timescale 1ns/1ps
package dsm5_pkg;
  typedef logic [2:0] lvl_t;
  localparam lvl_t LVL_MID = 3'd2;
  localparam lvl_t LVL_TOP = 3'd4;
  localparam int   NUM_STAGES = 4;
endpackage

// File: rtl/dsm5_step_ctl.sv
`timescale 1ns/1ps
module dsm5_step_ctl #(
  parameter int HOLD_LO = 4,
  parameter int HOLD_HI = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic rate_sel,
  output logic step_o
);
  localparam int CNT_W = $clog2(HOLD_HI + 1);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (in_valid) begin
      left_q <= rate_sel ? CNT_W'(HOLD_HI) : CNT_W'(HOLD_LO);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign step_o = (left_q != '0);
endmodule

// File: rtl/dsm5_quantizer.sv
`timescale 1ns/1ps
module dsm5_quantizer
  import dsm5_pkg::*;
#(
  parameter int Y_W     = 27,
  parameter int FB_W    = 24,
  parameter int STEP_SH = 14
) (
  input  logic signed [Y_W-1:0]  y_i,
  output lvl_t                   lvl_o,
  output logic signed [FB_W-1:0] fb_o
);
  localparam logic signed [Y_W-1:0] TH_NEAR = Y_W'(1) << (STEP_SH - 1);
  localparam logic signed [Y_W-1:0] TH_FAR  = Y_W'(3) << (STEP_SH - 1);

  // mid-tread decision: thresholds at +-0.5 and +-1.5 feedback steps
  function automatic lvl_t pick_level(input logic signed [Y_W-1:0] y);
    if (y >= TH_FAR)        return 3'd4;
    else if (y >= TH_NEAR)  return 3'd3;
    else if (y > -TH_NEAR)  return 3'd2;
    else if (y > -TH_FAR)   return 3'd1;
    else                    return 3'd0;
  endfunction

  // centred feedback value: (code - 2) scaled by one step
  function automatic logic signed [FB_W-1:0] level_to_fb(input lvl_t l);
    logic signed [FB_W-1:0] c;
    c = FB_W'(int'(l) - 2);
    return c <<< STEP_SH;
  endfunction

  assign lvl_o = pick_level(y_i);
  assign fb_o  = level_to_fb(lvl_o);
endmodule

// File: rtl/dsm5_loop_filter.sv
`timescale 1ns/1ps
module dsm5_loop_filter
  import dsm5_pkg::*;
#(
  parameter int W     = 24,
  parameter int A1_SH = 6,
  parameter int A2_SH = 7,
  parameter int B1_SH = 0,
  parameter int B2_SH = 4,
  parameter int B3_SH = 6,
  parameter int B4_SH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_i,
  input  logic signed [W-1:0]  err_i,
  output logic signed [W+2:0]  y_o,
  output logic                 s1_clamp_o
);
  localparam int XW = W + 2;
  localparam int YW = W + 3;
  localparam int B_SH [NUM_STAGES] = '{B1_SH, B2_SH, B3_SH, B4_SH};

  function automatic logic signed [XW-1:0] ext(input logic signed [W-1:0] a);
    return {{2{a[W-1]}}, a};
  endfunction

  function automatic logic signed [W-1:0] sat_w(input logic signed [XW-1:0] v);
    if (v > $signed({3'b000, {(W-1){1'b1}}}))      return {1'b0, {(W-1){1'b1}}};
    else if (v < $signed({3'b111, {(W-1){1'b0}}})) return {1'b1, {(W-1){1'b0}}};
    else                                           return v[W-1:0];
  endfunction

  logic signed [W-1:0]  st_q [NUM_STAGES];
  logic signed [XW-1:0] inc  [NUM_STAGES];
  logic signed [XW-1:0] raw  [NUM_STAGES];
  logic signed [W-1:0]  nxt  [NUM_STAGES];
  logic signed [W-1:0]  term [NUM_STAGES];

  // stage inputs: error, then cascade with two compensation feedbacks
  always_comb begin
    inc[0] = ext(err_i);
    inc[1] = ext(st_q[0]) - ext(st_q[2] >>> A1_SH);
    inc[2] = ext(st_q[1]) - ext(st_q[3] >>> A2_SH);
    inc[3] = ext(st_q[2]);
  end

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    assign raw[k]  = ext(st_q[k]) + inc[k];
    assign nxt[k]  = sat_w(raw[k]);
    assign term[k] = st_q[k] >>> B_SH[k];

    always_ff @(posedge clk) begin
      if (rst)         st_q[k] <= '0;
      else if (step_i) st_q[k] <= nxt[k];
    end
  end

  always_comb begin
    y_o = '0;
    for (int k = 0; k < NUM_STAGES; k++) begin
      y_o = y_o + {{(YW-W){term[k][W-1]}}, term[k]};
    end
  end

  assign s1_clamp_o = step_i && (ext(nxt[0]) != raw[0]);
endmodule

// File: rtl/dsm5_modulator.sv
`timescale 1ns/1ps
module dsm5_modulator
  import dsm5_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8,
  parameter int HOLD_LO = 4,
  parameter int HOLD_HI = 6,
  parameter int A1_SH   = 6,
  parameter int A2_SH   = 7,
  parameter int B1_SH   = 0,
  parameter int B2_SH   = 4,
  parameter int B3_SH   = 6,
  parameter int B4_SH   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              rate_sel,
  input  logic [DATA_W-1:0] in_data,
  output logic [2:0]        lvl_o,
  output logic              lvl_valid_o
);
  localparam int W       = DATA_W + GUARD_W;
  localparam int STEP_SH = DATA_W - 2;

  logic signed [DATA_W-1:0] x_q;
  logic                     step_w;
  logic                     s1_clamp_w;
  logic signed [W-1:0]      fb_w;
  logic signed [W-1:0]      err_w;
  logic signed [W+2:0]      y_w;
  lvl_t                     pick_w;
  lvl_t                     lvl_q;

  always_ff @(posedge clk) begin
    if (rst)           x_q <= '0;
    else if (in_valid) x_q <= $signed(in_data);
  end

  dsm5_step_ctl #(.HOLD_LO(HOLD_LO), .HOLD_HI(HOLD_HI)) u_step (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .rate_sel (rate_sel),
    .step_o   (step_w)
  );

  assign err_w = {{GUARD_W{x_q[DATA_W-1]}}, x_q} - fb_w;

  dsm5_loop_filter #(
    .W(W), .A1_SH(A1_SH), .A2_SH(A2_SH),
    .B1_SH(B1_SH), .B2_SH(B2_SH), .B3_SH(B3_SH), .B4_SH(B4_SH)
  ) u_filt (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_w),
    .err_i      (err_w),
    .y_o        (y_w),
    .s1_clamp_o (s1_clamp_w)
  );

  dsm5_quantizer #(.Y_W(W + 3), .FB_W(W), .STEP_SH(STEP_SH)) u_quant (
    .y_i   (y_w),
    .lvl_o (pick_w),
    .fb_o  (fb_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q       <= LVL_MID;
      lvl_valid_o <= 1'b0;
    end else begin
      lvl_valid_o <= step_w;
      if (step_w) lvl_q <= pick_w;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/dsm5_chk.sv
`timescale 1ns/1ps
module dsm5_chk #(
  parameter int HOLD_LO = 4,
  parameter int HOLD_HI = 6
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       rate_sel,
  input logic [2:0] lvl_o,
  input logic       lvl_valid_o,
  input logic       step_w,
  input logic       s1_clamp_w
);
  logic [7:0] burst_cnt;
  logic [7:0] burst_exp;

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_cnt <= '0;
      burst_exp <= '0;
    end else if (in_valid) begin
      burst_cnt <= '0;
      burst_exp <= rate_sel ? 8'(HOLD_HI) : 8'(HOLD_LO);
    end else if (step_w) begin
      burst_cnt <= burst_cnt + 8'd1;
    end
  end

  // R1
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_o <= 3'd4);

  // R2
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (lvl_o == 3'd2 && !lvl_valid_o));

  // R4
  burst_start_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> step_w);

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(step_w) |-> burst_cnt == burst_exp);

  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_w |=> $stable(lvl_o));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !s1_clamp_w);
endmodule

bind dsm5_modulator dsm5_chk #(.HOLD_LO(HOLD_LO), .HOLD_HI(HOLD_HI)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .rate_sel    (rate_sel),
  .lvl_o       (lvl_o),
  .lvl_valid_o (lvl_valid_o),
  .step_w      (step_w),
  .s1_clamp_w  (s1_clamp_w)
);

// File: tb/dsm5_modulator_tb_top.sv
`timescale 1ns/1ps
module dsm5_modulator_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        rate_sel = 1'b0;
  logic [15:0] in_data = '0;
  logic [2:0]  lvl;
  logic        lvl_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsm5_modulator dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rate_sel(rate_sel),
    .in_data(in_data), .lvl_o(lvl), .lvl_valid_o(lvl_valid)
  );

  typedef struct {
    int     n;
    longint x;
    bit     strict;
    string  tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: accumulate codes of the current window and compare on completion
  int       got = 0;
  longint   acc = 0;
  int       bad_range = 0;
  int       bad_strict = 0;
  int       bad_hold = 0;
  logic [2:0] prev_lvl = 3'd2;

  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      if (lvl_valid) begin
        got++;
        acc += (longint'(lvl) - 2) * 16384;
        if (lvl > 3'd4) bad_range++;
        if (exp_q[0].strict && lvl != 3'd2) bad_strict++;
      end else if (lvl != prev_lvl) begin
        bad_hold++;
      end
      if (got == exp_q[0].n) begin
        longint target;
        longint diff;
        target = longint'(exp_q[0].n) * exp_q[0].x;
        diff = acc - target;
        if (diff < 0) diff = -diff;
        check(diff <= 64'd4194304, {exp_q[0].tag, " R6 mean tracking"}, acc, target);
        check(bad_range == 0, {exp_q[0].tag, " R1 code range"}, bad_range, 0);
        check(bad_hold == 0, {exp_q[0].tag, " R7 hold between steps"}, bad_hold, 0);
        if (exp_q[0].strict)
          check(bad_strict == 0, {exp_q[0].tag, " flat code 2"}, bad_strict, 0);
        void'(exp_q.pop_front());
        got = 0; acc = 0; bad_range = 0; bad_strict = 0; bad_hold = 0;
      end
    end
    prev_lvl = lvl;
  end

  // driver: push the expectation, then strobe samples with garbage between
  task automatic run_window(input longint x, input bit rate, input int nsamp,
                            input bit strict, input string tag);
    exp_t e;
    e.n = nsamp * (rate ? 6 : 4);
    e.x = x;
    e.strict = strict;
    e.tag = tag;
    exp_q.push_back(e);
    for (int i = 0; i < nsamp; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = x[15:0];
      rate_sel = rate;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'(i * 13579) ^ 16'hA5A5;
      rate_sel = ~rate;
      repeat (6) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, {tag, " window complete"}, exp_q.size(), 0);
  endtask

  // R4: count valid cycles and first valid position after one strobe
  task automatic burst_check(input bit rate);
    int cnt;
    int first;
    cnt = 0;
    first = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'h0000;
    rate_sel = rate;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      rate_sel = ~rate;
      if (lvl_valid) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
    check(cnt == (rate ? 6 : 4), "R4 burst length", cnt, rate ? 6 : 4);
    check(first == 2, "R4 burst start", first, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R2: reset state
    check(lvl == 3'd2, "R2 reset code", lvl, 2);
    check(lvl_valid == 1'b0, "R2 reset valid", lvl_valid, 0);
    rst = 1'b0;

    run_window(0, 1'b0, 64, 1'b1, "R3 R5 zero input");
    burst_check(1'b0);
    burst_check(1'b1);
    run_window(16384, 1'b0, 1024, 1'b0, "R6 half positive");
    run_window(-16384, 1'b1, 768, 1'b0, "R6 half negative");
    run_window(8192, 1'b0, 1024, 1'b0, "R6 quarter positive");
    run_window(32767, 1'b1, 768, 1'b0, "R8 full positive");
    run_window(-32768, 1'b0, 1024, 1'b0, "R8 full negative");

    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(lvl == 3'd2 && lvl_valid == 1'b0, "R2 mid-run reset outputs", lvl, 2);
    rst = 1'b0;
    run_window(0, 1'b1, 64, 1'b1, "R2 cleared state");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule